// File: doc/BRIEF.md
# Dual-Path Frame Integrity Selector

This block watches two redundant copies of a single point-to-point Ethernet byte stream, called path A and path B. Each copy arrives as a byte-wide stream qualified by a valid strobe and a start-of-frame strobe. For each path, a frame checker follows the frame layout and checks the length field and the CRC. When a frame ends or is aborted, the checker emits a one-cycle verdict pulse.

A selector uses only these verdicts to decide which path the external switch should pass. The choice is sticky. The output moves away from the active path only when that path reports a failed frame and the other path's most recent verdict was good. One indicator per path shows which path is active. The block never forwards or buffers frame data, so the throughput is one byte per clock on each path. This is far above 10 Mbps at any practical clock rate.

Top module: `dps_selector`

## Requirements
- R1: A frame begins on a byte that has both strobes high. That byte and the next six bytes must each be 0x55, and the eighth byte must be 0xD5. Any other value fails the frame at that byte, and the checker returns to idle.
- R2: After 0xD5 the checker consumes 14 header bytes: 6 destination bytes, then 6 source bytes, then a 2-byte length sent most significant byte first. The length gives the number of data bytes that follow.
- R3: A length below 46 or above 1500 fails the frame on its second length byte. Later bytes are ignored until the next start-of-frame.
- R4: The CRC is CRC-32 with polynomial 0x04C11DB7, shifted LSB-first, with the register preset to all ones. It covers the header and data bytes. The 4 FCS bytes carry the complemented CRC, least significant byte first. The frame passes only if the residue after the last FCS byte equals the fixed good-frame constant.
- R5: A path's frame_done bit pulses for one cycle, in the cycle after the byte (or valid-low cycle) that ends the frame. frame_ok is high only together with a passing frame_done.
- R6: After reset, path A is selected, path_led is 2'b01, and both paths' last verdicts are unknown. An unknown verdict never counts as good.
- R7: The selection switches to the other path, one cycle after the active path's failing frame_done, when the other path's most recent verdict is good. A verdict reported in that same cycle counts as most recent.
- R8: When the active path fails and the other path's latest verdict is bad or unknown, the selection is kept. Passing frames never change the selection.
- R9: path_led is one-hot. Bit 0 marks path A and bit 1 marks path B, and it always agrees with sel_b (0 = A, 1 = B).
- R10: A valid-low cycle before the last FCS byte aborts the frame with a failing verdict.
- R11: A start-of-frame byte inside a frame aborts the old frame with a failing verdict and begins a new frame on that byte.
- R12: Bytes that have valid high but start-of-frame low while the checker is idle are ignored and produce no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pa_valid | input | 1 | Path A byte valid |
| pa_sof | input | 1 | Path A start-of-frame, marks first preamble byte |
| pa_data | input | 8 | Path A byte |
| pb_valid | input | 1 | Path B byte valid |
| pb_sof | input | 1 | Path B start-of-frame |
| pb_data | input | 8 | Path B byte |
| sel_b | output | 1 | Selected path, 0 = A, 1 = B |
| path_led | output | 2 | Active-path indicators, bit 0 = A, bit 1 = B |
| frame_done | output | 2 | Per-path verdict pulse, bit 0 = A |
| frame_ok | output | 2 | Per-path verdict, valid with frame_done |

## Verification
The assertions assume that each path holds valid high for the whole frame and that the start-of-frame strobe appears only together with valid. Under those assumptions, any valid-low or start-of-frame inside a frame is a deliberate abort. The bench builds every frame byte by byte from a CRC model of its own and keeps valid continuous except where an abort is intended. It sweeps every pairing of frame kinds across the two paths (good, bad CRC, bad length, truncated, bad preamble, bad delimiter, restarted, absent). It then checks each verdict, its cycle, and the selection against a model driven by the verdict pulses.

// File: rtl/dps_pkg.sv
package dps_pkg;

   typedef enum logic [2:0] {
      CK_IDLE,
      CK_PRE,
      CK_SFD,
      CK_HDR,
      CK_DATA,
      CK_FCS
   } chk_state_t;

   localparam logic [7:0]  PRE_BYTE   = 8'h55;
   localparam logic [7:0]  DELIM_BYTE = 8'hD5;
   localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

   function automatic logic [31:0] bit_reverse32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = v[31-i];
      return r;
   endfunction

endpackage

// File: rtl/dps_crc_unit.sv
module dps_crc_unit #(
   parameter bit          REFLECTED = 1'b1,
   parameter logic [31:0] POLY      = 32'h04C1_1DB7,
   parameter logic [31:0] RESIDUE   = REFLECTED ? 32'hDEBB_20E3 : 32'hC704_DD7B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic [7:0] data,
   output logic       residue_hit
);
   import dps_pkg::*;

   logic [31:0] crc_q;
   logic [31:0] crc_next;

   generate
      if (REFLECTED) begin : g_lsb_first
         localparam logic [31:0] POLY_R = bit_reverse32(POLY);
         always_comb begin
            logic [31:0] c;
            c = crc_q;
            for (int i = 0; i < 8; i++)
               c = (c[0] ^ data[i]) ? ((c >> 1) ^ POLY_R) : (c >> 1);
            crc_next = c;
         end
      end else begin : g_msb_first
         always_comb begin
            logic [31:0] c;
            c = crc_q;
            for (int i = 0; i < 8; i++)
               c = (c[31] ^ data[7-i]) ? ((c << 1) ^ POLY) : (c << 1);
            crc_next = c;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= CRC_PRESET;
      else if (clr) crc_q <= CRC_PRESET;
      else if (en)  crc_q <= crc_next;
   end

   assign residue_hit = (crc_next == RESIDUE);

   // R4: a clear always leaves the register at the preset
   p_clear_preset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (crc_q == CRC_PRESET));

endmodule

// File: rtl/dps_frame_checker.sv
module dps_frame_checker #(
   parameter int PRE_LEN       = 7,
   parameter int ADDR_BYTES    = 6,
   parameter int LEN_BYTES     = 2,
   parameter int MIN_DATA      = 46,
   parameter int MAX_DATA      = 1500,
   parameter int FCS_BYTES     = 4,
   parameter bit LEN_CHECK_EN  = 1'b1,
   parameter bit CRC_REFLECTED = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic       in_sof,
   input  logic [7:0] in_data,
   output logic       frame_done,
   output logic       frame_ok
);
   import dps_pkg::*;

   localparam int CNT_W   = 16;
   localparam int HDR_LEN = 2 * ADDR_BYTES + LEN_BYTES;

   generate
      if (PRE_LEN < 2)             begin : g_bad_pre  $error("PRE_LEN must be at least 2"); end
      if (LEN_BYTES != 2)          begin : g_bad_lenb $error("LEN_BYTES must be 2"); end
      if (MAX_DATA >= (1 << CNT_W)) begin : g_bad_max  $error("MAX_DATA exceeds counter"); end
      if (MIN_DATA > MAX_DATA)     begin : g_bad_min  $error("MIN_DATA above MAX_DATA"); end
      if (FCS_BYTES != 4)          begin : g_bad_fcs  $error("FCS_BYTES must be 4"); end
   endgenerate

   chk_state_t st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] len_q, len_d;
   logic [7:0]       hi_q, hi_d;
   logic             done_d, ok_d;
   logic             crc_clr, crc_en, crc_hit;
   logic [CNT_W-1:0] len_val;
   logic             len_bad;

   assign len_val = {hi_q, in_data};

   generate
      if (LEN_CHECK_EN) begin : g_len_range
         assign len_bad = (len_val < CNT_W'(MIN_DATA)) || (len_val > CNT_W'(MAX_DATA));
      end else begin : g_len_free
         assign len_bad = 1'b0;
      end
   endgenerate

   dps_crc_unit #(.REFLECTED(CRC_REFLECTED)) u_crc (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (crc_clr),
      .en          (crc_en),
      .data        (in_data),
      .residue_hit (crc_hit)
   );

   always_comb begin
      st_d    = st_q;
      cnt_d   = cnt_q;
      len_d   = len_q;
      hi_d    = hi_q;
      done_d  = 1'b0;
      ok_d    = 1'b0;
      crc_clr = 1'b0;
      crc_en  = 1'b0;
      if (st_q == CK_IDLE || (in_valid && in_sof)) begin
         if (st_q != CK_IDLE) done_d = 1'b1;
         if (in_valid && in_sof) begin
            if (in_data == PRE_BYTE) begin
               st_d  = CK_PRE;
               cnt_d = CNT_W'(1);
            end else begin
               st_d   = CK_IDLE;
               done_d = 1'b1;
            end
         end
      end else if (!in_valid) begin
         st_d   = CK_IDLE;
         done_d = 1'b1;
      end else begin
         case (st_q)
            CK_PRE: begin
               if (in_data != PRE_BYTE) begin
                  st_d   = CK_IDLE;
                  done_d = 1'b1;
               end else if (cnt_q == CNT_W'(PRE_LEN - 1)) begin
                  st_d  = CK_SFD;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            CK_SFD: begin
               if (in_data != DELIM_BYTE) begin
                  st_d   = CK_IDLE;
                  done_d = 1'b1;
               end else begin
                  st_d    = CK_HDR;
                  cnt_d   = '0;
                  crc_clr = 1'b1;
               end
            end
            CK_HDR: begin
               crc_en = 1'b1;
               if (cnt_q == CNT_W'(HDR_LEN - 2)) hi_d = in_data;
               if (cnt_q == CNT_W'(HDR_LEN - 1)) begin
                  cnt_d = '0;
                  len_d = len_val;
                  if (len_bad) begin
                     st_d   = CK_IDLE;
                     done_d = 1'b1;
                  end else if (len_val == '0) begin
                     st_d = CK_FCS;
                  end else begin
                     st_d = CK_DATA;
                  end
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            CK_DATA: begin
               crc_en = 1'b1;
               if (cnt_q == len_q - 1'b1) begin
                  st_d  = CK_FCS;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            CK_FCS: begin
               crc_en = 1'b1;
               if (cnt_q == CNT_W'(FCS_BYTES - 1)) begin
                  st_d   = CK_IDLE;
                  done_d = 1'b1;
                  ok_d   = crc_hit;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            default: begin
               st_d = CK_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= CK_IDLE;
         cnt_q      <= '0;
         len_q      <= '0;
         hi_q       <= '0;
         frame_done <= 1'b0;
         frame_ok   <= 1'b0;
      end else begin
         st_q       <= st_d;
         cnt_q      <= cnt_d;
         len_q      <= len_d;
         hi_q       <= hi_d;
         frame_done <= done_d;
         frame_ok   <= ok_d;
      end
   end

   // R10: losing valid inside a frame yields a failing verdict next cycle
   p_valid_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != CK_IDLE && !in_valid) |=> (frame_done && !frame_ok));

   // R11: a fresh start inside a frame yields a failing verdict next cycle
   p_restart_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != CK_IDLE && in_valid && in_sof) |=> (frame_done && !frame_ok));

   // R5: a pass is only ever reported together with a verdict pulse
   p_ok_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok |-> frame_done);

   // R12: an idle checker without a start produces no verdict
   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CK_IDLE && !(in_valid && in_sof)) |=> !frame_done);

   // R3: an out-of-range length ends the frame as a failure
   p_length_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CK_HDR && in_valid && !in_sof && cnt_q == CNT_W'(HDR_LEN - 1) && len_bad)
      |=> (frame_done && !frame_ok && st_q == CK_IDLE));

endmodule

// File: rtl/dps_path_select.sv
module dps_path_select #(
   parameter int NUM_PATHS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PATHS-1:0] done,
   input  logic [NUM_PATHS-1:0] ok,
   output logic                 sel_q,
   output logic [NUM_PATHS-1:0] led
);
   generate
      if (NUM_PATHS != 2) begin : g_bad_paths $error("exactly two paths supported"); end
   endgenerate

   logic [NUM_PATHS-1:0] good_q;
   logic [NUM_PATHS-1:0] fresh_good;
   logic                 act_fail;
   logic                 peer_good;

   generate
      for (genvar p = 0; p < NUM_PATHS; p++) begin : g_status
         assign fresh_good[p] = done[p] ? ok[p] : good_q[p];
         assign led[p]        = (sel_q == p[0]);
      end
   endgenerate

   assign act_fail  = done[sel_q] && !ok[sel_q];
   assign peer_good = fresh_good[!sel_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good_q <= '0;
         sel_q  <= 1'b0;
      end else begin
         for (int p = 0; p < NUM_PATHS; p++)
            if (done[p]) good_q[p] <= ok[p];
         if (act_fail && peer_good) sel_q <= !sel_q;
      end
   end

   // R8: without a failing verdict on the active path the selection holds
   p_hold_no_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done[sel_q] && !ok[sel_q]) |=> $stable(sel_q));

   // R7: a newly chosen path always has a good latest verdict
   p_switch_to_good_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q != $past(sel_q)) |-> good_q[sel_q]);

endmodule

// File: rtl/dps_selector.sv
module dps_selector #(
   parameter int PRE_LEN       = 7,
   parameter int ADDR_BYTES    = 6,
   parameter int MIN_DATA      = 46,
   parameter int MAX_DATA      = 1500,
   parameter bit LEN_CHECK_EN  = 1'b1,
   parameter bit CRC_REFLECTED = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pa_valid,
   input  logic       pa_sof,
   input  logic [7:0] pa_data,
   input  logic       pb_valid,
   input  logic       pb_sof,
   input  logic [7:0] pb_data,
   output logic       sel_b,
   output logic [1:0] path_led,
   output logic [1:0] frame_done,
   output logic [1:0] frame_ok
);
   localparam int NP = 2;

   logic [NP-1:0] v_in;
   logic [NP-1:0] s_in;
   logic [7:0]    d_in [NP];

   assign v_in    = {pb_valid, pa_valid};
   assign s_in    = {pb_sof, pa_sof};
   assign d_in[0] = pa_data;
   assign d_in[1] = pb_data;

   generate
      for (genvar p = 0; p < NP; p++) begin : g_path
         dps_frame_checker #(
            .PRE_LEN       (PRE_LEN),
            .ADDR_BYTES    (ADDR_BYTES),
            .LEN_BYTES     (2),
            .MIN_DATA      (MIN_DATA),
            .MAX_DATA      (MAX_DATA),
            .FCS_BYTES     (4),
            .LEN_CHECK_EN  (LEN_CHECK_EN),
            .CRC_REFLECTED (CRC_REFLECTED)
         ) u_chk (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (v_in[p]),
            .in_sof     (s_in[p]),
            .in_data    (d_in[p]),
            .frame_done (frame_done[p]),
            .frame_ok   (frame_ok[p])
         );
      end
   endgenerate

   dps_path_select #(.NUM_PATHS(NP)) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (frame_done),
      .ok    (frame_ok),
      .sel_q (sel_b),
      .led   (path_led)
   );

endmodule

// File: tb/dps_selector_test.sv
`timescale 1ns/1ps
module dps_selector_test;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n;
   logic       pa_valid, pa_sof, pb_valid, pb_sof;
   logic [7:0] pa_data, pb_data;
   logic       sel_b;
   logic [1:0] path_led, frame_done, frame_ok;

   dps_selector uut (
      .clk(clk), .rst_n(rst_n),
      .pa_valid(pa_valid), .pa_sof(pa_sof), .pa_data(pa_data),
      .pb_valid(pb_valid), .pb_sof(pb_sof), .pb_data(pb_data),
      .sel_b(sel_b), .path_led(path_led),
      .frame_done(frame_done), .frame_ok(frame_ok)
   );

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;
   bit finished = 0;

   logic [7:0] frm [2][0:2047];
   bit         fsof [2][0:2047];
   int flen [2];
   int fend [2];
   int fcnt [2];
   bit fok  [2];
   int fkind [2];

   int pcount [2];
   bit plast  [2];
   int pcyc   [2];

   bit exp_sel;
   int stat [2];   // 0 unknown, 1 good, 2 bad

   always @(posedge clk) cyc++;

   task automatic chk(input bit cond, input string req, input string what,
                      input longint act, input longint exp);
      nchk++;
      if (!cond) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic string kind_req(input int k);
      case (k)
         0, 1:    return "R4";
         2:       return "R3";
         3:       return "R10";
         4, 5:    return "R1";
         6:       return "R11";
         default: return "R12";
      endcase
   endfunction

   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB8_8320;
         else             r = r >> 1;
      end
      return r;
   endfunction

   // monitor: selection model driven by verdict pulses (R6, R7, R8, R9)
   always @(negedge clk) begin
      if (rst_n) begin
         bit act, oth, oth_good;
         chk(sel_b == exp_sel, "R7", "sel_b", sel_b, exp_sel);
         chk(path_led == (exp_sel ? 2'b10 : 2'b01), "R9", "path_led",
             path_led, exp_sel ? 2 : 1);
         for (int p = 0; p < 2; p++) begin
            if (frame_done[p]) begin
               pcount[p]++;
               plast[p] = frame_ok[p];
               pcyc[p]  = cyc;
            end
         end
         act = exp_sel;
         oth = !exp_sel;
         oth_good = frame_done[oth] ? frame_ok[oth] : (stat[oth] == 1);
         for (int p = 0; p < 2; p++)
            if (frame_done[p]) stat[p] = frame_ok[p] ? 1 : 2;
         if (frame_done[act] && !frame_ok[act] && oth_good) exp_sel = oth;
      end
   end

   task automatic build(input int p, input int kind, input int dlen);
      int n;
      logic [31:0] c;
      for (int i = 0; i < 2048; i++) begin
         fsof[p][i] = 1'b0;
         frm[p][i]  = 8'h00;
      end
      fkind[p] = kind;
      if (kind == 7) begin
         flen[p] = 0; fend[p] = 0; fcnt[p] = 0; fok[p] = 0;
         return;
      end
      n = 0;
      for (int i = 0; i < 7; i++) frm[p][n++] = 8'h55;
      frm[p][n++] = 8'hD5;
      for (int i = 0; i < 6; i++) frm[p][n++] = 8'h10 + 8'(i + p);
      for (int i = 0; i < 6; i++) frm[p][n++] = 8'h20 + 8'(i * 3);
      frm[p][n++] = 8'(dlen >> 8);
      frm[p][n++] = 8'(dlen);
      if (kind != 2)
         for (int i = 0; i < dlen; i++) frm[p][n++] = 8'(i * 7 + p * 3 + dlen);
      c = 32'hFFFF_FFFF;
      for (int i = 8; i < n; i++) c = crc_step(c, frm[p][i]);
      c = ~c;
      for (int i = 0; i < 4; i++) frm[p][n++] = c[8*i +: 8];
      fsof[p][0] = 1'b1;
      flen[p] = n; fend[p] = n - 1; fcnt[p] = 1; fok[p] = 1'b1;
      case (kind)
         1: begin frm[p][25] ^= 8'h01; fok[p] = 1'b0; end
         2: begin flen[p] = 22; fend[p] = 21; fok[p] = 1'b0; end
         3: begin flen[p] = 40; fend[p] = 40; fok[p] = 1'b0; end
         4: begin frm[p][3] = 8'h54; fend[p] = 3; fok[p] = 1'b0; end
         5: begin frm[p][7] = 8'hD4; fend[p] = 7; fok[p] = 1'b0; end
         6: begin
            for (int i = n - 1; i >= 0; i--) frm[p][i + 30] = frm[p][i];
            fsof[p][30] = 1'b1;
            flen[p] = n + 30; fend[p] = n + 29; fcnt[p] = 2;
         end
         default: ;
      endcase
   endtask

   task automatic run_pair(input int ka, input int kb, input int da, input int db);
      int m, base;
      build(0, ka, da);
      build(1, kb, db);
      pcount[0] = 0; pcount[1] = 0;
      m = (flen[0] > flen[1]) ? flen[0] : flen[1];
      base = 0;
      for (int i = 0; i < m; i++) begin
         @(negedge clk);
         if (i == 0) base = cyc;
         pa_valid = (i < flen[0]); pa_sof = fsof[0][i]; pa_data = frm[0][i];
         pb_valid = (i < flen[1]); pb_sof = fsof[1][i]; pb_data = frm[1][i];
      end
      @(negedge clk);
      pa_valid = 0; pa_sof = 0; pb_valid = 0; pb_sof = 0;
      repeat (4) @(negedge clk);
      for (int p = 0; p < 2; p++) begin
         chk(pcount[p] == fcnt[p], kind_req(fkind[p]), "verdict count", pcount[p], fcnt[p]);
         if (fcnt[p] > 0) begin
            chk(plast[p] == fok[p], kind_req(fkind[p]), "verdict", plast[p], fok[p]);
            chk(pcyc[p] == base + fend[p] + 1, "R5", "verdict cycle",
                pcyc[p], base + fend[p] + 1);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nerr++; nchk++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      rst_n = 0;
      pa_valid = 0; pa_sof = 0; pa_data = 0;
      pb_valid = 0; pb_sof = 0; pb_data = 0;
      exp_sel = 0; stat[0] = 0; stat[1] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R6: reset state
      chk(sel_b == 1'b0, "R6", "reset sel_b", sel_b, 0);
      chk(path_led == 2'b01, "R6", "reset path_led", path_led, 1);
      chk(frame_done == 2'b00, "R6", "reset frame_done", frame_done, 0);

      // R6: A fails while B is still unknown -> stay on A
      run_pair(4, 7, 60, 60);
      chk(sel_b == 1'b0, "R6", "unknown peer keeps A", sel_b, 0);

      // R7: A fails, B good -> switch to B
      run_pair(1, 0, 50, 50);
      chk(sel_b == 1'b1, "R7", "switch to B", sel_b, 1);
      // R8: both fail -> hold B
      run_pair(1, 3, 48, 70);
      chk(sel_b == 1'b1, "R8", "both fail holds", sel_b, 1);
      // R8: A good only, B active passes -> hold
      run_pair(0, 0, 46, 46);
      chk(sel_b == 1'b1, "R8", "pass holds", sel_b, 1);
      // R7: B fails, A good -> back to A
      run_pair(0, 5, 46, 46);
      chk(sel_b == 1'b0, "R7", "switch to A", sel_b, 0);

      // R2/R3: length boundaries
      run_pair(0, 0, 1500, 46);
      run_pair(2, 2, 45, 1501);
      run_pair(0, 2, 47, 0);

      // sweep of all kind pairings (R1, R2, R3, R4, R10, R11)
      for (int ka = 0; ka < 8; ka++) begin
         for (int kb = 0; kb < 8; kb++) begin
            int da, db;
            da = (ka == 2) ? ((kb % 2) ? 45 : 1501) : 46 + ((ka * 8 + kb) % 5) * 13;
            db = (kb == 2) ? ((ka % 2) ? 1501 : 45) : 46 + ((kb * 8 + ka) % 4) * 17;
            run_pair(ka, kb, da, db);
         end
      end

      // R12: stray bytes while idle produce no verdict
      pcount[0] = 0; pcount[1] = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         pa_valid = 1; pa_sof = 0; pa_data = (i % 2) ? 8'h55 : 8'hD5;
         pb_valid = 1; pb_sof = 0; pb_data = 8'(i);
      end
      @(negedge clk);
      pa_valid = 0; pb_valid = 0;
      repeat (3) @(negedge clk);
      chk(pcount[0] == 0, "R12", "stray A verdicts", pcount[0], 0);
      chk(pcount[1] == 0, "R12", "stray B verdicts", pcount[1], 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule